// File: doc/BRIEF.md
# SPI Slave Shift Register

This block is the serial end of an SPI slave running in clock phase 0. A byte offered on `tx_byte` is captured when the master pulls the select line low. Its first bit appears on `miso` before any serial clock edge arrives. For each bit, the leading SCK transition samples `mosi` and the trailing transition shifts the register, which puts the next outgoing bit on `miso`. After the eighth sample the received byte is presented on `rx_byte` with a one-cycle `rx_done` strobe.

The serial inputs are asynchronous to the system clock. SCK, MOSI and select each pass through a two-flop synchroniser, and every transition is detected in the system clock domain. The serial clock must therefore be several times slower than the system clock. The `cpol` input chooses which SCK transition leads. The `lsb_first` input chooses the bit order and is captured together with the transmit byte. Select must be released between bytes. Releasing it early aborts the byte.

The control state machine has four states:
- `ST_IDLE`: select is high.
- `ST_SAMPLE`: waiting for a leading edge.
- `ST_SHIFT`: waiting for a trailing edge.
- `ST_HOLD`: all bits taken, waiting for select to be released.

Transitions:
- IDLE→SAMPLE on a select fall.
- SAMPLE→SHIFT on a leading edge with bits remaining.
- SAMPLE→HOLD on the last leading edge.
- SHIFT→SAMPLE on a trailing edge.
- Any busy state →IDLE whenever the synchronised select is high.

Top module: `spi_slave_shifter`

## Requirements
- R1: After reset, `miso_oe` is 0, `miso` is 0, `rx_done` is 0 and `rx_byte` is 0.
- R2: A select fall captures `tx_byte` and `lsb_first`. Before any SCK edge, `miso` then shows bit 7 of the captured byte when `lsb_first` is 0, and bit 0 when it is 1.
- R3: Each leading SCK edge samples `mosi`. Each trailing edge shifts the register so that the next transmit bit appears on `miso`. A master sampling `miso` on leading edges receives the whole transmit byte in the chosen order.
- R4: With `cpol` = 0 the rising SCK transition leads. With `cpol` = 1 the falling transition leads and the rising one trails.
- R5: After the eighth leading edge, `rx_byte` holds the received byte and `rx_done` is high for exactly one system cycle. The first received bit lands in bit 7 when `lsb_first` is 0, and in bit 0 when it is 1.
- R6: If select rises before the eighth leading edge, no `rx_done` is raised and `rx_byte` keeps its old value. The next transfer starts again from bit zero and completes correctly.
- R7: After the eighth bit, further SCK edges while select stays low are ignored: no second strobe and no change to `rx_byte`.
- R8: While select is high, `miso_oe` is 0 and `miso` is held at 0.
- R9: If the select release and the eighth leading edge reach the system domain in the same cycle, the release wins. No strobe is raised and `rx_byte` is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpol | input | 1 | Clock polarity: 0 means the rising edge leads |
| lsb_first | input | 1 | Bit order: 1 means least significant bit first |
| tx_byte | input | 8 | Byte to send, captured at the select fall |
| sck | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data from the master |
| sel_n | input | 1 | Active-low slave select |
| miso | output | 1 | Serial data to the master, 0 when not enabled |
| miso_oe | output | 1 | Output enable for the MISO pad driver |
| rx_byte | output | 8 | Last completely received byte |
| rx_done | output | 1 | One-cycle strobe when `rx_byte` is updated |

## Verification
Two functions can fall in the same system cycle: completing the byte on its last sampling edge, and aborting on a select release. The bench provokes this by changing SCK to its leading level and raising select in the same time step. Both signals pass through identical synchronisers, so they are seen together. The outcome is judged at the ports: no strobe may appear, and `rx_byte` must still hold the byte from the previous transfer.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_SHIFT  = 2'd2,
        ST_HOLD   = 2'd3
    } slv_state_e;

endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
    parameter int             WIDTH   = 3,
    parameter int             STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] stg;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg <= RST_VAL;
                else        stg <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg <= {STAGES{RST_VAL}};
                else        stg <= {stg[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_slv_edges.sv
module spi_slv_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic cpol,
    input  logic sck_s,
    input  logic sel_s,
    output logic lead,
    output logic trail,
    output logic sel_fall
);

    logic sck_q;
    logic sel_q;
    logic rise;
    logic fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            sel_q <= 1'b1;
        end else begin
            sck_q <= sck_s;
            sel_q <= sel_s;
        end
    end

    assign rise     = !sck_q &&  sck_s;
    assign fall     =  sck_q && !sck_s;
    // polarity picks which transition samples (leading) and which shifts
    assign lead     = cpol ? fall : rise;
    assign trail    = cpol ? rise : fall;
    assign sel_fall = sel_q && !sel_s;

    assert_edges_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(lead && trail));

endmodule

// File: rtl/spi_slv_fsm.sv
module spi_slv_fsm
    import spi_slv_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lsb_first,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              mosi_s,
    input  logic              sel_s,
    input  logic              sel_fall,
    input  logic              lead,
    input  logic              trail,
    output logic              miso,
    output logic              miso_oe,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_done
);

    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    slv_state_e        st;
    slv_state_e        st_nxt;
    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic              samp;
    logic              order_lsb;
    logic              last_lead;

    assign last_lead = lead && (cnt == LAST_BIT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // next-state decode; select release dominates every busy state
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE:   if (sel_fall) st_nxt = ST_SAMPLE;
            ST_SAMPLE: begin
                if (sel_s)          st_nxt = ST_IDLE;
                else if (last_lead) st_nxt = ST_HOLD;
                else if (lead)      st_nxt = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (sel_s)      st_nxt = ST_IDLE;
                else if (trail) st_nxt = ST_SAMPLE;
            end
            ST_HOLD:   if (sel_s) st_nxt = ST_IDLE;
            default:   st_nxt = ST_IDLE;
        endcase
    end

    // datapath and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            cnt       <= '0;
            samp      <= 1'b0;
            order_lsb <= 1'b0;
            rx_byte   <= '0;
            rx_done   <= 1'b0;
        end else begin
            rx_done <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    cnt <= '0;
                    if (sel_fall) begin
                        shreg     <= tx_byte;
                        order_lsb <= lsb_first;
                    end
                end
                ST_SAMPLE: begin
                    if (sel_s) begin
                        cnt <= '0;
                    end else if (lead) begin
                        samp <= mosi_s;
                        cnt  <= cnt + 1'b1;
                        if (cnt == LAST_BIT) begin
                            rx_done <= 1'b1;
                            rx_byte <= order_lsb ? {mosi_s, shreg[DATA_W-1:1]}
                                                 : {shreg[DATA_W-2:0], mosi_s};
                        end
                    end
                end
                ST_SHIFT: begin
                    if (sel_s) begin
                        cnt <= '0;
                    end else if (trail) begin
                        shreg <= order_lsb ? {samp, shreg[DATA_W-1:1]}
                                           : {shreg[DATA_W-2:0], samp};
                    end
                end
                ST_HOLD: begin
                    if (sel_s) cnt <= '0;
                end
                default: cnt <= '0;
            endcase
        end
    end

    assign miso_oe = (st != ST_IDLE);
    assign miso    = miso_oe && (order_lsb ? shreg[0] : shreg[DATA_W-1]);

    assert_oe_from_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(miso_oe) |-> $past(sel_fall));
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done);
    assert_rx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_byte) |-> rx_done);
    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DATA_W));
    assert_oe_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sel_s |=> (!miso_oe && !miso));
    assert_release_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> !$past(sel_s));

endmodule

// File: rtl/spi_slave_shifter.sv
module spi_slave_shifter #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpol,
    input  logic              lsb_first,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              sck,
    input  logic              mosi,
    input  logic              sel_n,
    output logic              miso,
    output logic              miso_oe,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_done
);

    logic [2:0] pins_s;
    logic       sck_s;
    logic       mosi_s;
    logic       sel_s;
    logic       lead;
    logic       trail;
    logic       sel_fall;

    spi_slv_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sel_n, mosi, sck}),
        .q     (pins_s)
    );

    assign sel_s  = pins_s[2];
    assign mosi_s = pins_s[1];
    assign sck_s  = pins_s[0];

    spi_slv_edges u_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpol     (cpol),
        .sck_s    (sck_s),
        .sel_s    (sel_s),
        .lead     (lead),
        .trail    (trail),
        .sel_fall (sel_fall)
    );

    spi_slv_fsm #(
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .lsb_first (lsb_first),
        .tx_byte   (tx_byte),
        .mosi_s    (mosi_s),
        .sel_s     (sel_s),
        .sel_fall  (sel_fall),
        .lead      (lead),
        .trail     (trail),
        .miso      (miso),
        .miso_oe   (miso_oe),
        .rx_byte   (rx_byte),
        .rx_done   (rx_done)
    );

endmodule

// File: tb/tb_spi_slave_shifter.sv
module tb_spi_slave_shifter;

    localparam int HALF = 8;   // system cycles per SCK half period

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpol = 1'b0;
    logic       lsb_first = 1'b0;
    logic [7:0] tx_byte = '0;
    logic       sck = 1'b0;
    logic       mosi = 1'b0;
    logic       sel_n = 1'b1;
    logic       miso;
    logic       miso_oe;
    logic [7:0] rx_byte;
    logic       rx_done;

    int  n_checks = 0;
    int  n_fails  = 0;
    int  done_count = 0;
    int  dn;
    bit  finished = 1'b0;
    logic       first_bit;
    logic [7:0] mi;
    logic [7:0] prev_rx;

    always #2.5 clk = ~clk;

    spi_slave_shifter dut (
        .clk (clk), .rst_n (rst_n), .cpol (cpol), .lsb_first (lsb_first),
        .tx_byte (tx_byte), .sck (sck), .mosi (mosi), .sel_n (sel_n),
        .miso (miso), .miso_oe (miso_oe), .rx_byte (rx_byte), .rx_done (rx_done)
    );

    always @(negedge clk) if (rst_n && rx_done) done_count++;

    // {cpol, lsb_first, slave tx byte, master mosi byte}
    localparam logic [17:0] VECS [0:5] = '{
        {1'b0, 1'b0, 8'hA5, 8'h3C},
        {1'b0, 1'b1, 8'h81, 8'hC2},
        {1'b1, 1'b0, 8'h5A, 8'hF0},
        {1'b1, 1'b1, 8'h17, 8'h0E},
        {1'b0, 1'b0, 8'hFF, 8'h00},
        {1'b1, 1'b1, 8'h00, 8'hFF}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // nbits leading edges; coinc raises select together with the last one
    task automatic xfer(input bit cp, input bit lf, input logic [7:0] tx,
                        input logic [7:0] mo, input int nbits, input int nextra,
                        input bit coinc, output logic [7:0] rcv, output int dones);
        int start;
        rcv = '0;
        cpol = cp; lsb_first = lf; tx_byte = tx; sck = cp; sel_n = 1'b1;
        wait_cyc(HALF);
        start = done_count;
        sel_n = 1'b0;
        mosi  = lf ? mo[0] : mo[7];
        wait_cyc(HALF);
        for (int i = 0; i < nbits; i++) begin
            if (i == 0) first_bit = miso;
            rcv[lf ? i : 7 - i] = miso;
            if (coinc && i == nbits - 1) begin
                sck = ~cp; sel_n = 1'b1;
                wait_cyc(HALF);
            end else begin
                sck = ~cp;
                wait_cyc(HALF);
                sck = cp;
                if (i < 7) mosi = lf ? mo[i + 1] : mo[6 - i];
                wait_cyc(HALF);
            end
        end
        for (int k = 0; k < nextra; k++) begin
            sck = ~cp; mosi = ~mosi;
            wait_cyc(HALF);
            sck = cp;
            wait_cyc(HALF);
        end
        wait_cyc(HALF);
        dones = done_count - start;
        sck = cp;
        sel_n = 1'b1;
        wait_cyc(HALF);
    endtask

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(4);

        // R1 reset state
        chk("R1 oe", miso_oe, 0);
        chk("R1 miso", miso, 0);
        chk("R1 done", rx_done, 0);
        chk("R1 rx", rx_byte, 0);

        // table walk: R3 / R4 / R5
        for (int v = 0; v < 6; v++) begin
            xfer(VECS[v][17], VECS[v][16], VECS[v][15:8], VECS[v][7:0], 8, 0, 1'b0, mi, dn);
            chk("R3 master receives tx byte", mi, VECS[v][15:8]);
            chk(VECS[v][17] ? "R4 cpol1 rx byte" : "R5 rx byte", rx_byte, VECS[v][7:0]);
            chk("R5 single strobe", dn, 1);
            chk("R8 oe off after release", miso_oe, 0);
            chk("R8 miso idle", miso, 0);
        end

        // R2 first bit before any clock edge
        xfer(1'b0, 1'b0, 8'h80, 8'h11, 8, 0, 1'b0, mi, dn);
        chk("R2 msb first bit", first_bit, 1);
        xfer(1'b0, 1'b1, 8'h80, 8'h22, 8, 0, 1'b0, mi, dn);
        chk("R2 lsb first bit", first_bit, 0);
        chk("R2 lsb order byte", mi, 8'h80);

        // R6 abort mid-byte
        prev_rx = rx_byte;
        xfer(1'b0, 1'b0, 8'h3C, 8'h99, 4, 0, 1'b0, mi, dn);
        chk("R6 no strobe on abort", dn, 0);
        chk("R6 rx kept on abort", rx_byte, prev_rx);
        xfer(1'b0, 1'b0, 8'hC3, 8'h6D, 8, 0, 1'b0, mi, dn);
        chk("R6 restart rx", rx_byte, 8'h6D);
        chk("R6 restart tx", mi, 8'hC3);

        // R7 extra clocks ignored in hold
        xfer(1'b1, 1'b0, 8'h55, 8'hB4, 8, 3, 1'b0, mi, dn);
        chk("R7 one strobe only", dn, 1);
        chk("R7 rx unchanged by extra edges", rx_byte, 8'hB4);

        // R9 release coincides with last sampling edge
        prev_rx = rx_byte;
        xfer(1'b0, 1'b1, 8'h0F, 8'h4B, 8, 0, 1'b1, mi, dn);
        chk("R9 no strobe", dn, 0);
        chk("R9 rx kept", rx_byte, prev_rx);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(900us);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule